// File: doc/BRIEF.md
# PCI-X Initiator Termination Checker

A passive bus monitor that watches the sampled control lines of a PCI-X segment and judges how the initiator closes each transaction. It follows each transaction from its address phase to the clock on which the initiator lets go of IRDY#. Along the way it counts data phases against an expected count supplied with the transaction. It reports every breach of the initiator's ending rules, and any 64-bit request made with a command class that may not carry one.

The checker drives nothing on the bus. The clock on which FRAME# is first seen low while the bus is idle is taken as the address phase, and the clock after it as the attribute phase. A separate strobe marks each completed data phase. Let D be the first data phase and L the last. The IRDY# release clock is R = max(L+1, D+2).

Each rule has its own bit. The bit pulses for one clock after the clock on which the breach was sampled, and a sticky copy of it holds until reset. The bit positions are:

- 0: 64-bit request
- 1: FRAME# at the last phase
- 2: FRAME# versus TRDY#
- 3: late IRDY# release
- 4: early IRDY# release
- 5: master wait state
- 6: illegal termination

Top module: `pcix_term_chk`

## Requirements
- R1: In the address phase, REQ64# low with command class 0 (other) or 2 (Memory Read DWORD) sets error bit 0. Class 1 (memory) and class 3 (split completion) may carry REQ64#.
- R2: When the expected phase count is four or more, FRAME# must be high at the last data phase and low on every earlier clock of the transaction. Otherwise error bit 1 is set.
- R3: The clock on which FRAME# first goes high inside a transaction must come at least two clocks after the first clock with TRDY# low. Otherwise error bit 2 is set, including when TRDY# was never seen low.
- R4: IRDY# must be high on the release clock R. Otherwise error bit 3 is set.
- R5: IRDY# going high after the last data phase but before R sets error bit 4.
- R6: Once IRDY# has been low in a transaction, IRDY# high on any clock up to and including the last data phase sets error bit 5, which marks a master wait state.
- R7: FRAME# still low on the release clock R is an illegal termination and sets error bit 6.
- R8: Each error pulse lasts one clock, on the clock after the sample that caused it. Its sticky bit rises at the same time and stays set until reset.
- R9: A synchronous active-low reset clears all pulses and sticky bits and returns the tracker to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Sampled FRAME# |
| irdy_n | input | 1 | Sampled IRDY# |
| trdy_n | input | 1 | Sampled TRDY# |
| req64_n | input | 1 | Sampled REQ64# |
| cmd_cls | input | 2 | Command class: 0 other, 1 memory, 2 Memory Read DWORD, 3 split completion |
| dp_valid | input | 1 | High on each clock that completes a data phase |
| exp_phases | input | CNT_W | Expected data-phase count, taken in the address phase, at least 1 |
| err_pulse | output | 7 | One-clock error pulses, bit order as above |
| err_sticky | output | 7 | Sticky error flags |

## Verification
The assertions take it as given that the expected phase count is at least one and that dp_valid rises exactly the counted number of times between an address phase and the release clock. They also assume FRAME# is high again by the clock after R, so that no new transaction appears out of a late release. The stimulus builds every transaction from a fixed frame: address, attribute, IRDY# from the next clock, a number of target wait clocks, then the data phases. It moves the FRAME# and IRDY# release clocks by small offsets and can add one master wait clock. It only chooses FRAME# offsets that keep release at or before R+1, so each transaction stays separate in the monitor's view.

// File: rtl/pcix_tc_pkg.sv
// Shared types and error-bit indices for the PCI-X initiator termination checker.
package pcix_tc_pkg;

    typedef enum logic [1:0] {
        CLS_OTHER  = 2'd0,
        CLS_MEM    = 2'd1,
        CLS_MRD_DW = 2'd2,
        CLS_SPLIT  = 2'd3
    } cmd_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_TAIL = 2'd2
    } trk_st_e;

    localparam int NUM_ERR      = 7;
    localparam int E_REQ64      = 0;
    localparam int E_FRAME_LAST = 1;
    localparam int E_FRAME_TRDY = 2;
    localparam int E_IRDY_LATE  = 3;
    localparam int E_IRDY_EARLY = 4;
    localparam int E_WAIT       = 5;
    localparam int E_TERM       = 6;

    // Per-clock view of the transaction produced by the tracker
    typedef struct packed {
        logic busy;        // between address phase and last data phase
        logic tail;        // after last data phase, up to the release clock
        logic addr;        // this clock is an address phase
        logic last_dp;     // this clock completes the last data phase
        logic long_txn;    // expected count is four or more
        logic rel_clk;     // this clock is the IRDY# release clock
        logic frame_rise;  // first clock of FRAME# high in this transaction
        logic trdy_ok;     // TRDY# first asserted two or more clocks ago
        logic irdy_seen;   // IRDY# has been low earlier in the transaction
    } trk_info_t;

endpackage

// File: rtl/pcix_tc_tracker.sv
// Follows one transaction at a time: address phase, data-phase count,
// first TRDY# and first data phase ages, and the IRDY# release clock.
// Assumes exp_phases >= 1 and dp_valid pulses exactly exp_phases times.
module pcix_tc_tracker
    import pcix_tc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             trdy_n,
    input  logic             dp_valid,
    input  logic [CNT_W-1:0] exp_phases,
    output trk_info_t        info
);

    localparam int AGE_W = 2;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;
    localparam logic [AGE_W-1:0] AGE_REL = AGE_W'(2);
    localparam logic [CNT_W-1:0] LONG_MIN = CNT_W'(4);

    trk_st_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, exp_q;
    logic [AGE_W-1:0] trdy_age_q, fd_age_q, trdy_age_now;
    logic             trdy_seen_q, irdy_seen_q, frame_dropped_q;
    logic             addr, last_dp, rel_clk, frame_rise, in_txn;

    // Decode of the current clock against the tracked transaction
    always_comb begin
        addr         = (st_q == ST_IDLE) && !frame_n;
        last_dp      = (st_q == ST_BUSY) && dp_valid && (cnt_q == exp_q - 1'b1);
        rel_clk      = (st_q == ST_TAIL) && (fd_age_q >= AGE_REL);
        in_txn       = (st_q == ST_BUSY) || (st_q == ST_TAIL);
        frame_rise   = in_txn && frame_n && !frame_dropped_q;
        trdy_age_now = trdy_seen_q ? trdy_age_q : '0;
    end

    // Next-state selection for the transaction phase
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (addr)    st_d = ST_BUSY;
            ST_BUSY: if (last_dp) st_d = ST_TAIL;
            ST_TAIL: if (rel_clk) st_d = ST_IDLE;
            default:              st_d = ST_IDLE;
        endcase
    end

    // State and per-transaction counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q            <= ST_IDLE;
            cnt_q           <= '0;
            exp_q           <= '0;
            trdy_age_q      <= '0;
            fd_age_q        <= '0;
            trdy_seen_q     <= 1'b0;
            irdy_seen_q     <= 1'b0;
            frame_dropped_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (addr) begin
                cnt_q           <= '0;
                exp_q           <= exp_phases;
                trdy_age_q      <= '0;
                fd_age_q        <= '0;
                trdy_seen_q     <= 1'b0;
                irdy_seen_q     <= 1'b0;
                frame_dropped_q <= 1'b0;
            end else if (in_txn) begin
                if (st_q == ST_BUSY && dp_valid)
                    cnt_q <= cnt_q + 1'b1;
                if (st_q == ST_BUSY && dp_valid && cnt_q == '0)
                    fd_age_q <= AGE_W'(1);
                else if (fd_age_q != '0 && fd_age_q != AGE_MAX)
                    fd_age_q <= fd_age_q + 1'b1;
                if (!trdy_seen_q && !trdy_n) begin
                    trdy_seen_q <= 1'b1;
                    trdy_age_q  <= AGE_W'(1);
                end else if (trdy_seen_q && trdy_age_q != AGE_MAX) begin
                    trdy_age_q <= trdy_age_q + 1'b1;
                end
                if (st_q == ST_BUSY && !irdy_n)
                    irdy_seen_q <= 1'b1;
                if (frame_rise)
                    frame_dropped_q <= 1'b1;
            end
        end
    end

    // Pack the per-clock view for the rule logic
    always_comb begin
        info.busy       = (st_q == ST_BUSY);
        info.tail       = (st_q == ST_TAIL);
        info.addr       = addr;
        info.last_dp    = last_dp;
        info.long_txn   = (exp_q >= LONG_MIN);
        info.rel_clk    = rel_clk;
        info.frame_rise = frame_rise;
        info.trdy_ok    = (trdy_seen_q || !trdy_n) && (trdy_age_now >= AGE_REL);
        info.irdy_seen  = irdy_seen_q;
    end

    // R4
    tail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_TAIL && st_q == ST_TAIL) |-> ($past(fd_age_q) < AGE_REL));

    // R9
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (st_q != ST_TAIL));

endmodule

// File: rtl/pcix_tc_rules.sv
// Combinational rule evaluation: one violation bit per initiator rule,
// taken from the tracker's view and the raw sampled bus lines.
module pcix_tc_rules
    import pcix_tc_pkg::*;
(
    input  trk_info_t          info,
    input  logic               frame_n,
    input  logic               irdy_n,
    input  logic               req64_n,
    input  logic [1:0]         cmd_cls,
    output logic [NUM_ERR-1:0] viol
);

    logic bad_cls;

    // Evaluate every rule against the current clock
    always_comb begin
        bad_cls = (cmd_cls == CLS_OTHER) || (cmd_cls == CLS_MRD_DW);
        viol = '0;
        viol[E_REQ64]      = info.addr && !req64_n && bad_cls;
        viol[E_FRAME_LAST] = info.busy && info.long_txn &&
                             (info.last_dp ? !frame_n : frame_n);
        viol[E_FRAME_TRDY] = info.frame_rise && !info.trdy_ok;
        viol[E_IRDY_LATE]  = info.rel_clk && !irdy_n;
        viol[E_IRDY_EARLY] = info.tail && !info.rel_clk && irdy_n;
        viol[E_WAIT]       = info.busy && info.irdy_seen && irdy_n;
        viol[E_TERM]       = info.rel_clk && !frame_n;
    end

endmodule

// File: rtl/pcix_tc_flags.sv
// Registers each violation as a one-clock pulse and a sticky flag.
// Assumes viol is settled before the clock edge.
module pcix_tc_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] viol,
    output logic [N-1:0] pulse,
    output logic [N-1:0] sticky
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Pulse and sticky register for one rule
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pulse[i]  <= 1'b0;
                sticky[i] <= 1'b0;
            end else begin
                pulse[i]  <= viol[i];
                sticky[i] <= sticky[i] | viol[i];
            end
        end

        // R8
        sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(sticky[i])) |-> sticky[i]);

        // R8
        pulse_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[i] |-> sticky[i]);
    end

endmodule

// File: rtl/pcix_term_chk.sv
// Top of the PCI-X initiator termination checker: tracker, rule logic and
// error flag registers. Passive; assumes inputs are synchronous samples.
module pcix_term_chk
    import pcix_tc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_n,
    input  logic               irdy_n,
    input  logic               trdy_n,
    input  logic               req64_n,
    input  logic [1:0]         cmd_cls,
    input  logic               dp_valid,
    input  logic [CNT_W-1:0]   exp_phases,
    output logic [NUM_ERR-1:0] err_pulse,
    output logic [NUM_ERR-1:0] err_sticky
);

    trk_info_t          info;
    logic [NUM_ERR-1:0] viol;

    pcix_tc_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .trdy_n     (trdy_n),
        .dp_valid   (dp_valid),
        .exp_phases (exp_phases),
        .info       (info)
    );

    pcix_tc_rules u_rules (
        .info    (info),
        .frame_n (frame_n),
        .irdy_n  (irdy_n),
        .req64_n (req64_n),
        .cmd_cls (cmd_cls),
        .viol    (viol)
    );

    pcix_tc_flags #(.N(NUM_ERR)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .viol   (viol),
        .pulse  (err_pulse),
        .sticky (err_sticky)
    );

    // R1
    req64_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (info.addr && !req64_n && cmd_cls == CLS_OTHER) |=> err_pulse[E_REQ64]);

    // R6
    master_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (info.busy && info.irdy_seen && irdy_n) |=> err_pulse[E_WAIT]);

    // R4
    late_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (info.rel_clk && !irdy_n) |=> err_sticky[E_IRDY_LATE]);

endmodule

// File: tb/tb_pcix_term_chk.sv
module tb_pcix_term_chk;

    localparam int CLK_P = 10;
    localparam int NE    = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, req64_n = 1'b1;
    logic [1:0] cmd_cls = 2'd0;
    logic       dp_valid = 1'b0;
    logic [7:0] exp_phases = 8'd1;
    logic [NE-1:0] err_pulse, err_sticky;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pcix_term_chk #(.CNT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .trdy_n(trdy_n), .req64_n(req64_n), .cmd_cls(cmd_cls),
        .dp_valid(dp_valid), .exp_phases(exp_phases),
        .err_pulse(err_pulse), .err_sticky(err_sticky)
    );

    function automatic string tag(input int b);
        case (b)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1;
        req64_n = 1'b1; dp_valid = 1'b0;
    endtask

    // One transaction: n phases, tw target waits, FRAME#/IRDY# offsets, class, REQ64#, master wait
    task automatic run_txn(input int n, input int tw, input int fo, input int io,
                           input int cls, input int rq, input int wv);
        int d0, l, r, f, fp, rp, wclk;
        logic [NE-1:0] expm, por;
        int req64_cnt, req64_first;
        d0 = 2 + tw;
        l  = d0 + n - 1;
        r  = (l + 1 > d0 + 2) ? l + 1 : d0 + 2;
        f  = (n >= 4) ? l : r;
        fp = f + fo;
        rp = r + io;
        wclk = wv ? 3 : -1;
        if (fp < 1 || fp > r + 1) return;

        expm = '0;
        expm[0] = rq && (cls == 0 || cls == 2);            // R1
        expm[1] = (n >= 4) && (fp != l);                   // R2
        expm[2] = (fp < d0 + 2);                           // R3
        expm[3] = (io > 0);                                // R4
        expm[4] = (io < 0) && (n == 1);                    // R5
        expm[5] = ((io < 0) && (n > 1)) || wv;             // R6
        expm[6] = (fp > r);                                // R7

        @(negedge clk);
        rst_n = 1'b0; idle_bus();
        cmd_cls = 2'(cls); exp_phases = 8'(n);
        @(negedge clk);
        rst_n = 1'b1;
        check("R9", int'(err_sticky) | int'(err_pulse), 0);

        por = '0; req64_cnt = 0; req64_first = -1;
        for (int c = 0; c <= r + 4; c++) begin
            if (c > 0) begin
                @(negedge clk);
                por |= err_pulse;
                if (err_pulse[0]) begin
                    req64_cnt++;
                    if (req64_first < 0) req64_first = c - 1;
                end
            end
            frame_n  = !(c < fp);
            irdy_n   = !(c >= 2 && c < rp && c != wclk);
            trdy_n   = !(c >= d0 && c <= l);
            dp_valid = (c >= d0 && c <= l);
            req64_n  = !(rq != 0 && c == 0);
        end
        @(negedge clk);
        por |= err_pulse;
        idle_bus();

        for (int b = 0; b < NE; b++)
            check(tag(b), int'(err_sticky[b]), int'(expm[b]));
        // R8: every sticky bit came from a seen pulse
        check("R8", int'(por), int'(err_sticky));
        if (expm[0]) begin
            // R8: the 64-bit request pulse sits on the clock after the address phase only
            check("R8", req64_first, 0);
            check("R8", req64_cnt, 1);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", int'(err_pulse), 0);
        check("R9", int'(err_sticky), 0);
        for (int n = 1; n <= 5; n++)
            for (int tw = 0; tw <= 2; tw++)
                for (int fo = -2; fo <= 2; fo++)
                    for (int io = -1; io <= 1; io++)
                        for (int cls = 0; cls < 4; cls++)
                            for (int rq = 0; rq < 2; rq++)
                                for (int wv = 0; wv < 2; wv++)
                                    if (wv == 0 || tw == 2)
                                        run_txn(n, tw, fo, io, cls, rq, wv);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule